// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

This peripheral holds six down-counting timers behind a simple register bus: an address, write data, a write strobe and read data that is returned combinationally in the same cycle. Every channel has a control register, an interval register and a live count register. Two registers are shared by all channels: an interrupt-enable mask and a write-1-to-clear interrupt-status register. Two further words are plain scratch storage for a watchdog that is not modelled. All channels advance on one common tick-enable input. In the target system that input pulses at 240 kHz.

Each channel is a two-state machine. The states are `CH_STOP` and `CH_RUN`. A control write takes the transition to `CH_RUN` when its enable bit is 1 and to `CH_STOP` when it is 0. The same write can also copy the interval into the counter. In `CH_RUN`, every tick decrements the counter. A tick that finds the counter at zero is an expiry. On expiry, a periodic channel reloads its interval and stays in `CH_RUN`. A one-shot channel takes the expiry transition to `CH_STOP` and clears its own enable bit. Every expiry sets the channel's status bit. If the channel's interrupt is enabled, the expiry also produces a one-cycle pulse on the channel's interrupt line.

Top module: `interval_timer_bank`

## Requirements
- R1: After reset, the interrupt-enable, interrupt-status, interval and count registers read 0, the control registers read 0x4, all channels are stopped and `irq_o` is 0.
- R2: Byte addresses: interrupt enable is at 0x00 and interrupt status at 0x04. Channel n has its slot at 0x10*(n+1), with control at +0x0, interval at +0x4 and count at +0x8. Two watchdog storage words sit at 0x90 and 0x94. Control, interval, interrupt enable and the watchdog words read back what was last written. The enable and status registers are 6 bits wide, and their upper read bits are 0.
- R3: A channel sub-offset other than 0x0, 0x4 or 0x8 reads 0, and a write to it changes nothing. An address outside the map reads 0 and ignores writes. Writes to a count register do not change the counter.
- R4: Control bit 0 is enable, bit 1 is reload and bit 7 is one-shot mode. A control write with reload set loads the counter with the interval in that same cycle.
- R5: A control write with enable set starts the channel. A control write with enable clear stops it, and the counter holds its value. Enabling without reload resumes from the held count.
- R6: A running channel decrements by one on each cycle that has the tick enable high. A tick with the counter at 0 is an expiry. A control write in the same cycle takes precedence, and that tick is dropped.
- R7: In periodic mode (bit 7 = 0), an expiry reloads the interval and the channel keeps running, so it expires every interval+1 ticks.
- R8: In one-shot mode (bit 7 = 1), an expiry stops the channel. The counter stays 0 and control bit 0 reads back as 0.
- R9: An expiry of channel n sets status bit n whether or not interrupts are enabled. `irq_o[n]` is high for exactly the one cycle after the expiry edge, and only if enable bit n was 1.
- R10: Writing 1 to a status bit clears it, and bits written as 0 keep their value. When an expiry and a clear of the same bit occur in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Common count-enable strobe (240 kHz rate in use) |
| addr | input | 10 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| rdata | output | 32 | Read data for `addr`, same cycle |
| irq_o | output | 6 | Per-channel interrupt pulse |

## Verification
A channel stuck in the wrong state shows up at the next tick. The count register reads back the wrong value one cycle later. A lost or extra reload appears at the expiry edge as a count other than the interval, and as an extra or missing status bit on the very next read. An error in the enable mask or the pulse register appears on `irq_o` in the single cycle after expiry and nowhere else, so the checks sample that one cycle exactly and the cycle after it.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int CTRL_EN_BIT     = 0;
    localparam int CTRL_RELOAD_BIT = 1;
    localparam int CTRL_MODE_BIT   = 7;
    localparam int CTRL_RESET_VAL  = 4;

    localparam int IEN_OFS  = 'h00;
    localparam int IST_OFS  = 'h04;

    localparam logic [3:0] SUB_CTRL = 4'h0;
    localparam logic [3:0] SUB_INTV = 4'h4;
    localparam logic [3:0] SUB_CNT  = 4'h8;

    localparam int WDOG_WORDS = 2;

    typedef enum logic {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ctrl_we,
    input  logic              intv_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] intv_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expire_o
);

    ch_state_e         state_q, state_d;
    logic [DATA_W-1:0] ctrl_d, intv_d, cnt_d;
    logic              expire;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_STOP;
            ctrl_q  <= DATA_W'(CTRL_RESET_VAL);
            intv_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            ctrl_q  <= ctrl_d;
            intv_q  <= intv_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state and output process
    always_comb begin
        state_d = state_q;
        ctrl_d  = ctrl_q;
        cnt_d   = cnt_q;
        intv_d  = intv_we ? wdata : intv_q;
        expire  = 1'b0;
        if (ctrl_we) begin
            ctrl_d = wdata;
            if (wdata[CTRL_RELOAD_BIT]) begin
                cnt_d = intv_q;
            end
            state_d = wdata[CTRL_EN_BIT] ? CH_RUN : CH_STOP;
        end else begin
            unique case (state_q)
                CH_STOP: begin
                    state_d = CH_STOP;
                end
                CH_RUN: begin
                    if (tick_en) begin
                        if (cnt_q == '0) begin
                            expire = 1'b1;
                            if (ctrl_q[CTRL_MODE_BIT]) begin
                                state_d             = CH_STOP;
                                ctrl_d[CTRL_EN_BIT] = 1'b0;
                            end else begin
                                cnt_d = intv_q;
                            end
                        end else begin
                            cnt_d = cnt_q - DATA_W'(1);
                        end
                    end
                end
                default: state_d = CH_STOP;
            endcase
        end
    end

    assign expire_o = expire;

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && tick_en && !ctrl_we && cnt_q != '0)
        |=> cnt_q == $past(cnt_q) - DATA_W'(1));

    assert_stop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STOP && !ctrl_we) |=> $stable(cnt_q));

    assert_periodic_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !ctrl_q[CTRL_MODE_BIT]) |=> (cnt_q == $past(intv_q) && state_q == CH_RUN));

    assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && ctrl_q[CTRL_MODE_BIT])
        |=> (state_q == CH_STOP && !ctrl_q[CTRL_EN_BIT] && cnt_q == '0));

endmodule

// File: rtl/pit_irq_ctrl.sv
module pit_irq_ctrl #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_we,
    input  logic              st_we,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] expire_i,
    output logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] st_q,
    output logic [NUM_CH-1:0] irq_o
);

    logic [NUM_CH-1:0] clr_mask;

    assign clr_mask = st_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            st_q  <= '0;
            irq_o <= '0;
        end else begin
            if (en_we) begin
                en_q <= wbits;
            end
            st_q  <= (st_q & ~clr_mask) | expire_i;
            irq_o <= expire_i & en_q;
        end
    end

    assert_status_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire_i) |=> ((st_q & $past(expire_i)) == $past(expire_i)));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> ((irq_o & ~$past(en_q)) == '0));

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> ((irq_o & ~$past(expire_i)) == '0));

    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && expire_i == '0) |=> st_q == ($past(st_q) & ~$past(wbits)));

endmodule

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
    import pit_pkg::*;
#(
    parameter int NUM_CH    = 6,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 10,
    parameter int WDOG_BASE = 'h90
) (
    input  logic [ADDR_W-1:0]                          addr,
    input  logic                                       wr_en,
    input  logic [NUM_CH-1:0][DATA_W-1:0]              ch_ctrl,
    input  logic [NUM_CH-1:0][DATA_W-1:0]              ch_intv,
    input  logic [NUM_CH-1:0][DATA_W-1:0]              ch_cnt,
    input  logic [NUM_CH-1:0]                          ien_q,
    input  logic [NUM_CH-1:0]                          ist_q,
    input  logic [WDOG_WORDS-1:0][DATA_W-1:0]          wdog_q,
    output logic [NUM_CH-1:0]                          ctrl_we,
    output logic [NUM_CH-1:0]                          intv_we,
    output logic                                       ien_we,
    output logic                                       ist_we,
    output logic [WDOG_WORDS-1:0]                      wdog_we,
    output logic [DATA_W-1:0]                          rdata
);

    localparam int SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    logic [3:0]        sub;

    assign slot   = addr[ADDR_W-1:4];
    assign sub    = addr[3:0];
    assign ien_we = wr_en && (addr == ADDR_W'(IEN_OFS));
    assign ist_we = wr_en && (addr == ADDR_W'(IST_OFS));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch_we
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(n + 1);
        assign ctrl_we[n] = wr_en && (slot == MY_SLOT) && (sub == SUB_CTRL);
        assign intv_we[n] = wr_en && (slot == MY_SLOT) && (sub == SUB_INTV);
    end

    for (genvar w = 0; w < WDOG_WORDS; w++) begin : g_wd_we
        assign wdog_we[w] = wr_en && (addr == ADDR_W'(WDOG_BASE + 4 * w));
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(IEN_OFS)) begin
            rdata = DATA_W'(ien_q);
        end else if (addr == ADDR_W'(IST_OFS)) begin
            rdata = DATA_W'(ist_q);
        end else begin
            for (int w = 0; w < WDOG_WORDS; w++) begin
                if (addr == ADDR_W'(WDOG_BASE + 4 * w)) begin
                    rdata = wdog_q[w];
                end
            end
            for (int n = 0; n < NUM_CH; n++) begin
                if (slot == SLOT_W'(n + 1)) begin
                    case (sub)
                        SUB_CTRL: rdata = ch_ctrl[n];
                        SUB_INTV: rdata = ch_intv[n];
                        SUB_CNT:  rdata = ch_cnt[n];
                        default:  rdata = '0;
                    endcase
                end
            end
        end
    end

    always_comb begin
        assert_one_strobe_R2: assert ($onehot0({ctrl_we, intv_we, ien_we, ist_we, wdog_we}));
    end

endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
    import pit_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq_o
);

    localparam int WDOG_BASE = 16 * (NUM_CH + 3);

    logic [NUM_CH-1:0][DATA_W-1:0]     ch_ctrl, ch_intv, ch_cnt;
    logic [NUM_CH-1:0]                 ctrl_we, intv_we, expire;
    logic [NUM_CH-1:0]                 ien_q, ist_q;
    logic                              ien_we, ist_we;
    logic [WDOG_WORDS-1:0]             wdog_we;
    logic [WDOG_WORDS-1:0][DATA_W-1:0] wdog_q;

    pit_bus_decode #(
        .NUM_CH   (NUM_CH),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .WDOG_BASE(WDOG_BASE)
    ) u_decode (
        .addr   (addr),
        .wr_en  (wr_en),
        .ch_ctrl(ch_ctrl),
        .ch_intv(ch_intv),
        .ch_cnt (ch_cnt),
        .ien_q  (ien_q),
        .ist_q  (ist_q),
        .wdog_q (wdog_q),
        .ctrl_we(ctrl_we),
        .intv_we(intv_we),
        .ien_we (ien_we),
        .ist_we (ist_we),
        .wdog_we(wdog_we),
        .rdata  (rdata)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pit_channel #(
            .DATA_W(DATA_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .ctrl_we (ctrl_we[n]),
            .intv_we (intv_we[n]),
            .wdata   (wdata),
            .ctrl_q  (ch_ctrl[n]),
            .intv_q  (ch_intv[n]),
            .cnt_q   (ch_cnt[n]),
            .expire_o(expire[n])
        );
    end

    pit_irq_ctrl #(
        .NUM_CH(NUM_CH)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_we   (ien_we),
        .st_we   (ist_we),
        .wbits   (wdata[NUM_CH-1:0]),
        .expire_i(expire),
        .en_q    (ien_q),
        .st_q    (ist_q),
        .irq_o   (irq_o)
    );

    for (genvar w = 0; w < WDOG_WORDS; w++) begin : g_wdog
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wdog_q[w] <= '0;
            end else if (wdog_we[w]) begin
                wdog_q[w] <= wdata;
            end
        end
    end

endmodule

// File: tb/interval_timer_bank_test.sv
module interval_timer_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;
    logic [5:0]  irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    interval_timer_bank uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_en(tick_en),
        .addr   (addr),
        .wdata  (wdata),
        .wr_en  (wr_en),
        .rdata  (rdata),
        .irq_o  (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic chk_irq(input logic [5:0] exp, input string req);
        check(req, {26'b0, irq_o}, {26'b0, exp});
    endtask

    task automatic test_reset();
        for (int n = 0; n < 6; n++) begin
            rd(10'(16 * (n + 1)),     32'h4, "R1 control default");
            rd(10'(16 * (n + 1) + 4), 32'h0, "R1 interval zero");
            rd(10'(16 * (n + 1) + 8), 32'h0, "R1 count zero");
        end
        rd(10'h000, 32'h0, "R1 irq enable zero");
        rd(10'h004, 32'h0, "R1 irq status zero");
        chk_irq(6'h0, "R1 irq lines low");
    endtask

    task automatic test_map();
        wr(10'h044, 32'h5);
        rd(10'h044, 32'h5, "R2 interval readback");
        wr(10'h000, 32'h3F);
        rd(10'h000, 32'h3F, "R2 irq enable readback");
        wr(10'h000, 32'hFFFF_FFC5);
        rd(10'h000, 32'h05, "R2 irq enable upper bits zero");
        wr(10'h000, 32'h0);
        wr(10'h090, 32'hA5A5_0001);
        wr(10'h094, 32'h0000_1234);
        rd(10'h090, 32'hA5A5_0001, "R2 watchdog word 0");
        rd(10'h094, 32'h0000_1234, "R2 watchdog word 1");
        wr(10'h04C, 32'hFFFF_FFFF);
        rd(10'h04C, 32'h0, "R3 bad sub-offset reads zero");
        rd(10'h040, 32'h4, "R3 bad sub-offset left control alone");
        rd(10'h044, 32'h5, "R3 bad sub-offset left interval alone");
        wr(10'h048, 32'h9);
        rd(10'h048, 32'h0, "R3 count write ignored");
        wr(10'h070, 32'h1234);
        rd(10'h070, 32'h0, "R3 unmapped slot reads zero");
        rd(10'h080, 32'h0, "R3 unmapped address reads zero");
        rd(10'h004, 32'h0, "R3 no status side effect");
        chk_irq(6'h0, "R3 no irq from bus writes");
    endtask

    task automatic test_periodic();
        wr(10'h000, 32'h1);
        wr(10'h014, 32'h3);
        tick_en = 1'b1;
        wr(10'h010, 32'h3);
        rd(10'h018, 32'h3, "R4 reload on control write");
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            rd(10'h018, 32'(3 - k), "R6 decrement per tick");
            chk_irq(6'h0, "R6 no irq before expiry");
        end
        @(negedge clk);
        rd(10'h018, 32'h3, "R7 periodic reload at expiry");
        chk_irq(6'h01, "R9 irq pulse on expiry");
        rd(10'h004, 32'h1, "R9 status set on expiry");
        @(negedge clk);
        chk_irq(6'h00, "R9 irq pulse single cycle");
        rd(10'h018, 32'h2, "R7 keeps running after reload");
        wr(10'h004, 32'h1);
        rd(10'h004, 32'h0, "R10 write one clears");
        rd(10'h018, 32'h1, "R6 count after clear write");
        wr(10'h010, 32'h0);
        rd(10'h018, 32'h1, "R6 control write drops coincident tick");
        repeat (3) @(negedge clk);
        rd(10'h018, 32'h1, "R5 stopped count holds");
        rd(10'h004, 32'h0, "R5 stopped channel no expiry");
        chk_irq(6'h00, "R5 stopped channel no irq");
        tick_en = 1'b0;
    endtask

    task automatic test_oneshot();
        wr(10'h000, 32'h2);
        wr(10'h024, 32'h2);
        tick_en = 1'b1;
        wr(10'h020, 32'h83);
        rd(10'h028, 32'h2, "R4 one-shot load");
        @(negedge clk);
        rd(10'h028, 32'h1, "R6 one-shot decrement");
        @(negedge clk);
        rd(10'h028, 32'h0, "R6 one-shot reaches zero");
        chk_irq(6'h00, "R6 zero is not yet expiry");
        @(negedge clk);
        chk_irq(6'h02, "R9 one-shot irq pulse");
        rd(10'h004, 32'h2, "R9 one-shot status");
        rd(10'h020, 32'h82, "R8 enable bit cleared");
        rd(10'h028, 32'h0, "R8 count stays zero");
        repeat (4) begin
            @(negedge clk);
            chk_irq(6'h00, "R8 no further pulses");
            rd(10'h028, 32'h0, "R8 stopped at zero");
        end
        rd(10'h004, 32'h2, "R8 status unchanged after stop");
        tick_en = 1'b0;
    endtask

    task automatic test_gate();
        wr(10'h000, 32'h0);
        wr(10'h034, 32'h1);
        tick_en = 1'b1;
        wr(10'h030, 32'h83);
        @(negedge clk);
        rd(10'h038, 32'h0, "R6 count at zero");
        @(negedge clk);
        chk_irq(6'h00, "R9 masked expiry gives no pulse");
        rd(10'h004, 32'h6, "R9 masked expiry still sets status");
        rd(10'h030, 32'h82, "R8 masked one-shot clears enable");
        @(negedge clk);
        chk_irq(6'h00, "R9 masked channel stays quiet");
        tick_en = 1'b0;
    endtask

    task automatic test_reload_enable();
        wr(10'h054, 32'h7);
        tick_en = 1'b1;
        wr(10'h050, 32'h2);
        rd(10'h058, 32'h7, "R4 reload without enable");
        rd(10'h050, 32'h2, "R2 control readback");
        repeat (3) @(negedge clk);
        rd(10'h058, 32'h7, "R5 not running without enable");
        wr(10'h050, 32'h1);
        rd(10'h058, 32'h7, "R5 enable without reload keeps count");
        @(negedge clk);
        rd(10'h058, 32'h6, "R5 resumes from held value");
        @(negedge clk);
        rd(10'h058, 32'h5, "R6 second decrement");
        wr(10'h050, 32'h0);
        rd(10'h058, 32'h5, "R5 stop holds count");
        tick_en = 1'b0;
    endtask

    task automatic test_w1c();
        rd(10'h004, 32'h6, "R10 status before partial clear");
        wr(10'h004, 32'h2);
        rd(10'h004, 32'h4, "R10 partial clear");
        wr(10'h004, 32'h0);
        rd(10'h004, 32'h4, "R10 zero write keeps bits");
        wr(10'h004, 32'h4);
        rd(10'h004, 32'h0, "R10 last bit cleared");
        // interval 0: channel 0 expires on every tick
        wr(10'h014, 32'h0);
        tick_en = 1'b1;
        wr(10'h010, 32'h3);
        @(negedge clk);
        rd(10'h004, 32'h1, "R7 zero interval expires each tick");
        wr(10'h004, 32'h1);
        rd(10'h004, 32'h1, "R10 set wins over clear");
        wr(10'h010, 32'h0);
        wr(10'h004, 32'h1);
        rd(10'h004, 32'h0, "R10 clear after stop");
        chk_irq(6'h00, "R9 masked periodic no pulse");
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_map();
        test_periodic();
        test_oneshot();
        test_gate();
        test_reload_enable();
        test_w1c();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule